// File: doc/BRIEF.md
# DRAM ECC Error Injector

This block sits on the write path of a memory controller, after the ECC encoder and before the DRAM write datapath. It lets software corrupt selected bits of one outgoing 144-bit codeword so that the error detection and reporting logic downstream can be tested. The codeword holds 128 data bits and 16 check bits, seen as nine 16-bit words. Words 0 to 7 are data at bits `16k+15:16k`, and word 8 is the check word at bits 143:128.

Software programs two 32-bit registers through a simple register slave. The target register selects the injection array and one 16-byte quarter of a 64-byte line. The control register holds a 9-bit word mask, one 16-bit flip vector shared by all selected words, two readable request flags and an arm flag. Once armed, the block corrupts the next DRAM write whose quarter index matches. In that write, every masked word is XORed with the flip vector. The arm flag then clears, and software polls it to see that the injection is done. Writes that are not corrupted pass straight through, with no register in the path.

Top module: `ecc_err_inject`

## Requirements
- R1: After reset, both registers read as zero and no write is corrupted.
- R2: Target register (`reg_sel_i`=0): bits 31:28 hold the array selector and bits 2:1 hold the quarter index. All other bits read as 0.
- R3: Control register (`reg_sel_i`=1): bits 28:20 hold the word mask, bit 18 the error-enable flag, bit 17 the arm flag, bit 16 the read-request flag and bits 15:0 the flip vector. All other bits read as 0.
- R4: A control write sets the arm flag only when write-data bit 17 is 1, the written mask and vector are both nonzero, and the stored selector is 8. Otherwise the arm flag reads 0.
- R5: When the block is armed, the selector is 8, `wr_valid_i` is 1 and `wr_addr_i[5:4]` equals the quarter index, `wr_cw_o` in the same cycle is `wr_cw_i` with each word k whose mask bit k is 1 XORed with the flip vector.
- R6: The arm flag clears in the cycle after an injection, so exactly one write beat is corrupted.
- R7: A write with no strobe, a write to another quarter, or any write while unarmed leaves `wr_cw_o` equal to `wr_cw_i` in the same cycle.
- R8: If a control write lands in the same cycle as an injection, the written value decides the next arm flag.
- R9: While the selector is not 8, an armed block corrupts nothing and stays armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 1 | Register select: 0 target, 1 control |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Read data of the selected register |
| wr_valid_i | input | 1 | DRAM write beat strobe |
| wr_addr_i | input | ADDR_W | Write address; bits 5:4 give the quarter |
| wr_cw_i | input | 144 | Codeword from the ECC encoder |
| wr_cw_o | output | 144 | Codeword toward DRAM |

## Verification
On every cycle the assertions check the following: an injection happens only when the block is armed with selector 8, an uninjected beat leaves the codeword untouched, an injected beat always differs from its input, and the arm flag clears after an injection unless a control write overrides it. Which bits flip, the register field layout, the rejection of zero masks and vectors, and the override on a same-cycle write can only be shown by the bench's directed and random scenarios, which compare against a reference model.

// File: rtl/ecc_inj_pkg.sv
package ecc_inj_pkg;
  localparam int WORD_W       = 16;
  localparam int N_DATA       = 8;
  localparam int N_WORDS      = N_DATA + 1;
  localparam int CW_W         = WORD_W * N_WORDS;
  localparam int REG_W        = 32;
  localparam int SEL_W        = 4;
  localparam int SEL_LSB      = 28;
  localparam int QUAD_W       = 2;
  localparam int QUAD_REG_LSB = 1;
  localparam int MASK_LSB     = 20;
  localparam int EN_BIT       = 18;
  localparam int ARM_BIT      = 17;
  localparam int RDQ_BIT      = 16;
  localparam logic [SEL_W-1:0] SEL_ECC = 4'h8;

  typedef struct packed {
    logic [SEL_W-1:0]  sel;
    logic [QUAD_W-1:0] quad;
  } tgt_reg_t;

  typedef struct packed {
    logic [N_WORDS-1:0] mask;
    logic               err_en;
    logic               arm;
    logic               rd_req;
    logic [WORD_W-1:0]  vec;
  } ctl_reg_t;

  typedef enum logic {REG_TGT = 1'b0, REG_CTL = 1'b1} reg_sel_e;
endpackage

// File: rtl/ecc_inj_regs.sv
module ecc_inj_regs
  import ecc_inj_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reg_we_i,
  input  logic             reg_sel_i,
  input  logic [REG_W-1:0] reg_wdata_i,
  output logic [REG_W-1:0] reg_rdata_o,
  input  logic             hit_i,
  output tgt_reg_t         tgt_o,
  output ctl_reg_t         ctl_o
);
  tgt_reg_t tgt_q;
  ctl_reg_t ctl_q;

  logic [N_WORDS-1:0] w_mask;
  logic [WORD_W-1:0]  w_vec;
  logic               arm_ok;
  logic               tgt_we, ctl_we;
  logic               unused_wdata;

  assign unused_wdata = ^reg_wdata_i;
  assign w_mask = reg_wdata_i[MASK_LSB +: N_WORDS];
  assign w_vec  = reg_wdata_i[WORD_W-1:0];
  assign tgt_we = reg_we_i && (reg_sel_i == REG_TGT);
  assign ctl_we = reg_we_i && (reg_sel_i == REG_CTL);
  // zero mask or vector would inject nothing: refuse to arm
  assign arm_ok = reg_wdata_i[ARM_BIT] && (|w_mask) && (|w_vec) && (tgt_q.sel == SEL_ECC);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tgt_q <= '0;
    end else if (tgt_we) begin
      tgt_q.sel  <= reg_wdata_i[SEL_LSB +: SEL_W];
      tgt_q.quad <= reg_wdata_i[QUAD_REG_LSB +: QUAD_W];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q <= '0;
    end else if (ctl_we) begin
      ctl_q.mask   <= w_mask;
      ctl_q.err_en <= reg_wdata_i[EN_BIT];
      ctl_q.arm    <= arm_ok;
      ctl_q.rd_req <= reg_wdata_i[RDQ_BIT];
      ctl_q.vec    <= w_vec;
    end else if (hit_i) begin
      ctl_q.arm <= 1'b0;
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    if (reg_sel_i == REG_TGT) begin
      reg_rdata_o[SEL_LSB +: SEL_W]       = tgt_q.sel;
      reg_rdata_o[QUAD_REG_LSB +: QUAD_W] = tgt_q.quad;
    end else begin
      reg_rdata_o[MASK_LSB +: N_WORDS] = ctl_q.mask;
      reg_rdata_o[EN_BIT]              = ctl_q.err_en;
      reg_rdata_o[ARM_BIT]             = ctl_q.arm;
      reg_rdata_o[RDQ_BIT]             = ctl_q.rd_req;
      reg_rdata_o[WORD_W-1:0]          = ctl_q.vec;
    end
  end

  assign tgt_o = tgt_q;
  assign ctl_o = ctl_q;

  assert_arm_clears_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_i && !ctl_we) |=> !ctl_q.arm);

  assert_write_wins_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_i && ctl_we) |=> (ctl_q.arm == $past(arm_ok)));

  assert_arm_source_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ctl_q.arm) |-> $past(ctl_we && reg_wdata_i[ARM_BIT]));

  assert_armed_nonzero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_q.arm |-> ((|ctl_q.mask) && (|ctl_q.vec)));
endmodule

// File: rtl/ecc_inj_match.sv
module ecc_inj_match
  import ecc_inj_pkg::*;
#(
  parameter int ADDR_W   = 6,
  parameter int QUAD_LSB = 4
) (
  input  logic              arm_i,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic [QUAD_W-1:0] quad_i,
  input  logic              wr_valid_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  output logic              hit_o
);
  logic unused_addr;
  assign unused_addr = ^wr_addr_i;
  assign hit_o = arm_i && (sel_i == SEL_ECC) && wr_valid_i &&
                 (wr_addr_i[QUAD_LSB +: QUAD_W] == quad_i);
endmodule

// File: rtl/ecc_inj_xor.sv
module ecc_inj_xor
  import ecc_inj_pkg::*;
(
  input  logic               en_i,
  input  logic [N_WORDS-1:0] mask_i,
  input  logic [WORD_W-1:0]  vec_i,
  input  logic [CW_W-1:0]    cw_i,
  output logic [CW_W-1:0]    cw_o
);
  for (genvar k = 0; k < N_WORDS; k++) begin : g_word
    assign cw_o[k*WORD_W +: WORD_W] = cw_i[k*WORD_W +: WORD_W] ^
                                      ({WORD_W{en_i & mask_i[k]}} & vec_i);
  end
endmodule

// File: rtl/ecc_err_inject.sv
module ecc_err_inject
  import ecc_inj_pkg::*;
#(
  parameter int ADDR_W   = 6,
  parameter int QUAD_LSB = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic              reg_sel_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  output logic [REG_W-1:0]  reg_rdata_o,
  input  logic              wr_valid_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [CW_W-1:0]   wr_cw_i,
  output logic [CW_W-1:0]   wr_cw_o
);
  tgt_reg_t tgt;
  ctl_reg_t ctl;
  logic     hit;

  ecc_inj_regs u_regs (
    .clk_i, .rst_ni, .reg_we_i, .reg_sel_i, .reg_wdata_i, .reg_rdata_o,
    .hit_i (hit),
    .tgt_o (tgt),
    .ctl_o (ctl)
  );

  ecc_inj_match #(.ADDR_W(ADDR_W), .QUAD_LSB(QUAD_LSB)) u_match (
    .arm_i      (ctl.arm),
    .sel_i      (tgt.sel),
    .quad_i     (tgt.quad),
    .wr_valid_i (wr_valid_i),
    .wr_addr_i  (wr_addr_i),
    .hit_o      (hit)
  );

  ecc_inj_xor u_xor (
    .en_i   (hit),
    .mask_i (ctl.mask),
    .vec_i  (ctl.vec),
    .cw_i   (wr_cw_i),
    .cw_o   (wr_cw_o)
  );

  assert_pass_through_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit |-> (wr_cw_o == wr_cw_i));

  assert_flip_visible_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit |-> (wr_cw_o != wr_cw_i));

  assert_hit_gated_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit |-> (ctl.arm && tgt.sel == SEL_ECC && wr_valid_i));

  assert_one_shot_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit && !(reg_we_i && reg_sel_i == REG_CTL)) |=> !hit);
endmodule

// File: tb/sim_ecc_err_inject.sv
`timescale 1ns/1ps
module sim_ecc_err_inject;
  localparam int CW = 144;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           reg_we = 1'b0;
  logic           reg_sel = 1'b0;
  logic [31:0]    reg_wdata = '0;
  logic [31:0]    reg_rdata;
  logic           wr_valid = 1'b0;
  logic [5:0]     wr_addr = '0;
  logic [CW-1:0]  wr_cw = '0;
  logic [CW-1:0]  wr_cw_out;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  // reference model state
  logic [3:0]  m_sel;
  logic [1:0]  m_quad;
  logic [8:0]  m_mask;
  logic        m_en, m_arm, m_rd;
  logic [15:0] m_vec;

  always #2 clk = ~clk;

  ecc_err_inject u0 (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(reg_we), .reg_sel_i(reg_sel),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .wr_valid_i(wr_valid),
    .wr_addr_i(wr_addr), .wr_cw_i(wr_cw), .wr_cw_o(wr_cw_out)
  );

  function automatic logic [31:0] exp_rd(input logic sel);
    logic [31:0] r = '0;
    if (!sel) begin
      r[31:28] = m_sel; r[2:1] = m_quad;
    end else begin
      r[28:20] = m_mask; r[18] = m_en; r[17] = m_arm; r[16] = m_rd; r[15:0] = m_vec;
    end
    return r;
  endfunction

  function automatic logic exp_hit(input logic v, input logic [5:0] a);
    return m_arm && (m_sel == 4'h8) && v && (a[5:4] == m_quad);
  endfunction

  function automatic logic [CW-1:0] exp_cw(input logic h, input logic [CW-1:0] c);
    logic [CW-1:0] r = c;
    for (int k = 0; k < 9; k++)
      if (h && m_mask[k]) r[k*16 +: 16] = r[k*16 +: 16] ^ m_vec;
    return r;
  endfunction

  function automatic logic [CW-1:0] rnd_cw();
    return {$urandom(), $urandom(), $urandom(), $urandom(), $urandom()};
  endfunction

  task automatic check32(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic check_cw(input string req, input logic [CW-1:0] act, input logic [CW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: act=%h exp=%h", req, act, exp);
    end
  endtask

  // one cycle: drive at negedge, check comb outputs, commit at posedge, update model
  task automatic step(input string req, input logic we, input logic sel, input logic [31:0] wd,
                      input logic v, input logic [5:0] a, input logic [CW-1:0] c);
    logic h;
    @(negedge clk);
    reg_we = we; reg_sel = sel; reg_wdata = wd; wr_valid = v; wr_addr = a; wr_cw = c;
    #1;
    h = exp_hit(v, a);
    check_cw(req, wr_cw_out, exp_cw(h, c));
    check32({req, " rd"}, reg_rdata, exp_rd(sel));
    @(posedge clk);
    #0;
    if (we && !sel) begin
      m_sel = wd[31:28]; m_quad = wd[2:1];
    end
    if (we && sel) begin
      m_arm = wd[17] && (wd[28:20] != 0) && (wd[15:0] != 0) && (m_sel == 4'h8);
      m_mask = wd[28:20]; m_en = wd[18]; m_rd = wd[16]; m_vec = wd[15:0];
    end else if (h) begin
      m_arm = 1'b0;
    end
  endtask

  task automatic idle_read(input string req, input logic sel);
    step(req, 1'b0, sel, 32'h0, 1'b0, 6'h0, rnd_cw());
  endtask

  initial begin
    #400000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: act=timeout exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    m_sel = '0; m_quad = '0; m_mask = '0; m_en = 0; m_arm = 0; m_rd = 0; m_vec = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    #1;
    check32("R1 tgt reset", reg_rdata, 32'h0);
    rst_n = 1'b1;
    idle_read("R1 tgt", 1'b0);
    idle_read("R1 ctl", 1'b1);
    step("R1 no inject", 1'b0, 1'b1, 0, 1'b1, 6'h00, rnd_cw());

    // R2: field layout of the target register
    step("R2 write", 1'b1, 1'b0, 32'hFFFF_FFFF, 1'b0, 6'h0, rnd_cw());
    idle_read("R2", 1'b0);
    check32("R2 value", exp_rd(1'b0), 32'hF000_0006);

    // R3/R4: selector 0xF -> control fields stored, arm refused
    step("R3 write", 1'b1, 1'b1, 32'hFFFF_FFFF, 1'b0, 6'h0, rnd_cw());
    idle_read("R3", 1'b1);
    check32("R4 no arm sel!=8", exp_rd(1'b1), 32'h1FF5_FFFF);

    // arm: selector 8, quarter 2, mask words 0,2,8, vector 0x00F0
    step("R2 sel8", 1'b1, 1'b0, 32'h8000_0004, 1'b0, 6'h0, rnd_cw());
    step("R4 arm", 1'b1, 1'b1, (32'h105 << 20) | (1 << 17) | 32'h00F0, 1'b0, 6'h0, rnd_cw());
    idle_read("R4 armed", 1'b1);
    check32("R4 arm bit", {31'h0, m_arm}, 32'h1);
    step("R7 other quarter", 1'b0, 1'b1, 0, 1'b1, 6'h10, rnd_cw());
    step("R7 no strobe", 1'b0, 1'b1, 0, 1'b0, 6'h20, rnd_cw());
    step("R5 inject", 1'b0, 1'b1, 0, 1'b1, 6'h23, {CW{1'b0}});
    idle_read("R6 cleared", 1'b1);
    step("R6 one shot", 1'b0, 1'b1, 0, 1'b1, 6'h20, rnd_cw());

    // R4: zero mask, zero vector refused
    step("R4 zero mask", 1'b1, 1'b1, (1 << 17) | 32'h0001, 1'b0, 6'h0, rnd_cw());
    idle_read("R4 zero mask", 1'b1);
    step("R4 zero vec", 1'b1, 1'b1, (32'h1FF << 20) | (1 << 17), 1'b0, 6'h0, rnd_cw());
    idle_read("R4 zero vec", 1'b1);
    step("R7 unarmed", 1'b0, 1'b1, 0, 1'b1, 6'h20, rnd_cw());

    // R8: injection and rearm write in the same cycle
    step("R8 arm", 1'b1, 1'b1, (32'h100 << 20) | (1 << 17) | 32'hA5A5, 1'b0, 6'h0, rnd_cw());
    step("R8 hit+write", 1'b1, 1'b1, (32'h0FF << 20) | (1 << 17) | 32'h8001, 1'b1, 6'h20, rnd_cw());
    idle_read("R8 still armed", 1'b1);
    step("R8 second inject", 1'b0, 1'b1, 0, 1'b1, 6'h2F, rnd_cw());

    // R9: selector moved away while armed
    step("R9 arm", 1'b1, 1'b1, (32'h001 << 20) | (1 << 17) | 32'hFFFF, 1'b0, 6'h0, rnd_cw());
    step("R9 sel3", 1'b1, 1'b0, 32'h3000_0004, 1'b0, 6'h0, rnd_cw());
    step("R9 suppressed", 1'b0, 1'b1, 0, 1'b1, 6'h20, rnd_cw());
    idle_read("R9 held", 1'b1);
    step("R9 sel8", 1'b1, 1'b0, 32'h8000_0004, 1'b0, 6'h0, rnd_cw());
    step("R9 resumed", 1'b0, 1'b1, 0, 1'b1, 6'h20, rnd_cw());

    // constrained random mix
    for (int i = 0; i < 2000; i++) begin
      logic        we, sel;
      logic [31:0] wd;
      we  = ($urandom() % 4) == 0;
      sel = $urandom() % 2;
      wd  = $urandom();
      if (!sel && ($urandom() % 4 != 0)) wd[31:28] = 4'h8;
      if (sel && ($urandom() % 2 == 0)) wd[17] = 1'b1;
      step("R5 R6 R7 random", we, sel, wd, ($urandom() % 2) == 0, 6'($urandom()), rnd_cw());
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule